// File: doc/BRIEF.md
# Vector Mask Enable and Write-Back Unit

This unit sits next to a vector register file and handles the one-bit-per-element view of a mask register. On the read side it turns the contents of a mask register into a vector of per-element enable bits. It has two interpretations of the same register. In predication mode the bits gate which elements an operation updates. In carry mode the bits feed the carry or borrow inputs of add-with-carry and subtract-with-borrow operations. The `vm` bit means opposite things in the two modes. With `vm=1`, predication treats every element as active, while carry mode treats every carry-in as zero.

On the write side the unit takes freshly computed mask results and merges them into the old destination contents. Only the elements below the element count change; the bits above it keep their previous value. The merged word is registered and presented with a one-cycle valid strobe, tagged with the destination register index. An element count outside 1..VLEN raises an error flag, forces all enables low and suppresses the write-back.

Top module: `vmask_unit`

## Requirements
- R1: Element i always uses bit i of the mask register, one bit per element, independent of element width.
- R2: In predication mode (`rd_carry=0`) with `vm=1`, enable bits 0..elem_cnt-1 are all 1 whatever `mask_reg` holds.
- R3: In carry mode (`rd_carry=1`) with `vm=1`, every enable (carry-in) bit is 0.
- R4: With `vm=0`, in either mode, `enable_o[i]` equals `mask_reg[i]` for every i below `elem_cnt`.
- R5: A write-back word has bit i equal to `wr_new[i]` for i < elem_cnt and equal to `wr_old[i]` for i >= elem_cnt.
- R6: `enable_o[i]` is 0 for every i >= elem_cnt in both modes.
- R7: `cnt_err` is 1 exactly when elem_cnt is 0 or greater than VLEN. While it is 1, `enable_o` is all zero and a `wr_req` in that cycle gives no `wb_valid` on the next cycle.
- R8: A `wr_req` with a legal count gives `wb_valid=1` on the cycle after, with the merged word on `wb_data` and `wr_idx` on `wb_idx`. Without `wr_req`, `wb_valid` is 0 on the next cycle.
- R9: After reset `wb_valid` is 0 and `wb_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_carry | input | 1 | Read mode: 0 predication, 1 carry/borrow input |
| vm | input | 1 | Unmasked flag from the instruction |
| elem_cnt | input | CNT_W | Number of elements in the operation |
| mask_reg | input | VLEN | Current contents of the mask source register |
| enable_o | output | VLEN | Per-element enable or carry-in bits (combinational) |
| cnt_err | output | 1 | Element count outside 1..VLEN (combinational) |
| wr_req | input | 1 | Request a mask write-back this cycle |
| wr_idx | input | IDX_W | Destination register index |
| wr_old | input | VLEN | Current contents of the destination register |
| wr_new | input | VLEN | Newly computed mask result bits |
| wb_valid | output | 1 | Registered write-back strobe |
| wb_idx | output | IDX_W | Registered destination index |
| wb_data | output | VLEN | Registered merged write-back word |

## Verification
The assertions take for granted that `rd_carry`, `vm`, `elem_cnt`, `wr_old` and `wr_new` are settled before each rising edge and hold through it. The write-back checks compare the registered word against the values seen one edge earlier. The bench changes every input on the falling edge only, so each edge sees one stable vector. It covers both legal extremes of the count (1 and VLEN) and illegal counts on both sides (0, VLEN+1 and the largest encodable value), so the error path and the tail-keeping path both run under the same timing.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic {
    MODE_PRED  = 1'b0,
    MODE_CARRY = 1'b1
  } mask_mode_e;

  typedef struct packed {
    logic vm;
    logic src;
  } mask_bit_t;
endpackage

// File: rtl/vmask_prefix.sv
module vmask_prefix #(
  parameter int VLEN  = 64,
  parameter int CNT_W = $clog2(VLEN) + 1
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [VLEN-1:0]  below,
  output logic             ok
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(VLEN);

  for (genvar i = 0; i < VLEN; i++) begin : g_thermo
    assign below[i] = (CNT_W'(i) < cnt);
  end

  assign ok = (cnt != '0) && (cnt <= MAX_CNT);
endmodule

// File: rtl/vmask_read.sv
module vmask_read
  import vmask_pkg::*;
#(
  parameter int VLEN = 64
) (
  input  mask_mode_e      mode,
  input  logic            vm,
  input  logic [VLEN-1:0] src,
  input  logic [VLEN-1:0] below,
  input  logic            ok,
  output logic [VLEN-1:0] en
);
  function automatic logic pick_bit(input mask_mode_e m, input mask_bit_t b);
    if (m == MODE_CARRY) return ~b.vm & b.src;
    else                 return b.vm | b.src;
  endfunction

  for (genvar i = 0; i < VLEN; i++) begin : g_bit
    mask_bit_t b;
    assign b.vm  = vm;
    assign b.src = src[i];
    assign en[i] = ok & below[i] & pick_bit(mode, b);
  end
endmodule

// File: rtl/vmask_merge.sv
module vmask_merge #(
  parameter int VLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             ok,
  input  logic [VLEN-1:0]  below,
  input  logic [IDX_W-1:0] idx,
  input  logic [VLEN-1:0]  old_bits,
  input  logic [VLEN-1:0]  new_bits,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [VLEN-1:0]  wb_data
);
  function automatic logic [VLEN-1:0] splice(input logic [VLEN-1:0] keep_sel,
                                             input logic [VLEN-1:0] fresh,
                                             input logic [VLEN-1:0] prior);
    return (fresh & keep_sel) | (prior & ~keep_sel);
  endfunction

  logic            fire;
  logic [VLEN-1:0] merged;

  assign fire   = req & ok;
  assign merged = splice(below, new_bits, old_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= fire;
      if (fire) begin
        wb_idx  <= idx;
        wb_data <= merged;
      end
    end
  end

  // R8
  fire_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wb_valid);
  // R7
  blocked_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ok) |=> !wb_valid);
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int VLEN  = 64,
  parameter int IDX_W = 5,
  parameter int CNT_W = $clog2(VLEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_carry,
  input  logic             vm,
  input  logic [CNT_W-1:0] elem_cnt,
  input  logic [VLEN-1:0]  mask_reg,
  output logic [VLEN-1:0]  enable_o,
  output logic             cnt_err,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VLEN-1:0]  wr_old,
  input  logic [VLEN-1:0]  wr_new,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [VLEN-1:0]  wb_data
);
  logic [VLEN-1:0] below;
  logic            cnt_ok;
  mask_mode_e      mode;

  assign mode    = mask_mode_e'(rd_carry);
  assign cnt_err = ~cnt_ok;

  vmask_prefix #(.VLEN(VLEN), .CNT_W(CNT_W)) u_prefix (
    .cnt   (elem_cnt),
    .below (below),
    .ok    (cnt_ok)
  );

  vmask_read #(.VLEN(VLEN)) u_read (
    .mode  (mode),
    .vm    (vm),
    .src   (mask_reg),
    .below (below),
    .ok    (cnt_ok),
    .en    (enable_o)
  );

  vmask_merge #(.VLEN(VLEN), .IDX_W(IDX_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (wr_req),
    .ok       (cnt_ok),
    .below    (below),
    .idx      (wr_idx),
    .old_bits (wr_old),
    .new_bits (wr_new),
    .wb_valid (wb_valid),
    .wb_idx   (wb_idx),
    .wb_data  (wb_data)
  );

  // R3
  carry_vm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_carry && vm) |-> (enable_o == '0));
  // R2
  pred_vm_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_carry && vm && !cnt_err) |-> ($countones(enable_o) == int'(elem_cnt)));
  // R6
  tail_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((enable_o >> elem_cnt) == '0));
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |-> (enable_o == '0));
  // R5
  tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !cnt_err) |=> (((wb_data ^ $past(wr_old)) >> $past(elem_cnt)) == '0));
endmodule

// File: tb/tb_vmask_unit.sv
module tb_vmask_unit;
  localparam int VLEN  = 64;
  localparam int IDX_W = 5;
  localparam int CNT_W = $clog2(VLEN) + 1;

  typedef struct {
    logic [VLEN-1:0]  data;
    logic [IDX_W-1:0] idx;
  } wb_item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_carry = 1'b0, vm = 1'b0, wr_req = 1'b0;
  logic [CNT_W-1:0] elem_cnt = '0;
  logic [VLEN-1:0]  mask_reg = '0, wr_old = '0, wr_new = '0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [VLEN-1:0]  enable_o, wb_data;
  logic             cnt_err, wb_valid;
  logic [IDX_W-1:0] wb_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  wb_item_t exp_q[$];

  always #5 clk = ~clk;

  vmask_unit #(.VLEN(VLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .rd_carry(rd_carry), .vm(vm), .elem_cnt(elem_cnt),
    .mask_reg(mask_reg), .enable_o(enable_o), .cnt_err(cnt_err), .wr_req(wr_req),
    .wr_idx(wr_idx), .wr_old(wr_old), .wr_new(wr_new), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic check(input bit ok, input string req, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: apply one vector, check the combinational read side, queue the write-back.
  task automatic apply(input bit carry, input bit vmb, input int cnt,
                       input logic [VLEN-1:0] msk, input bit wr,
                       input logic [IDX_W-1:0] idx, input logic [VLEN-1:0] oldv,
                       input logic [VLEN-1:0] newv, input string tag);
    logic [VLEN-1:0] exp_en;
    logic [VLEN-1:0] exp_wb;
    bit legal;
    @(negedge clk);
    rd_carry = carry; vm = vmb; elem_cnt = CNT_W'(cnt); mask_reg = msk;
    wr_req = wr; wr_idx = idx; wr_old = oldv; wr_new = newv;
    legal = (cnt >= 1) && (cnt <= VLEN);
    for (int i = 0; i < VLEN; i++) begin
      if (!legal || i >= cnt) exp_en[i] = 1'b0;
      else if (vmb)           exp_en[i] = carry ? 1'b0 : 1'b1;
      else                    exp_en[i] = msk[i];
      exp_wb[i] = (i < cnt) ? newv[i] : oldv[i];
    end
    #1;
    check(enable_o == exp_en, {tag, " enable"}, enable_o, exp_en);
    check(cnt_err == !legal, "R7 cnt_err", VLEN'(cnt_err), VLEN'(!legal));
    if (wr && legal) exp_q.push_back('{data: exp_wb, idx: idx});
  endtask

  // Monitor: compare each registered write-back with the queue head.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (wb_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7/R8 unexpected wb_valid", wb_data, '0);
        end else begin
          wb_item_t e;
          e = exp_q.pop_front();
          check(wb_data == e.data, "R5 wb_data", wb_data, e.data);
          check(wb_idx == e.idx, "R8 wb_idx", VLEN'(wb_idx), VLEN'(e.idx));
        end
      end else if (exp_q.size() != 0) begin
        check(1'b0, "R8 missing wb_valid", '0, exp_q[0].data);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] pat = 64'hA5C3_0F96_1E78_D24B;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(wb_valid == 1'b0, "R9 wb_valid at reset", VLEN'(wb_valid), '0);
    check(wb_data == '0, "R9 wb_data at reset", wb_data, '0);
    rst_n = 1'b1;
    // R2 predication, vm=1, full and partial counts
    apply(0, 1, VLEN, '0, 1, 5'd3, pat, ~pat, "R2 pred vm full");
    apply(0, 1, 10, 64'h0, 1, 5'd7, '1, '0, "R2 pred vm partial R6");
    // R3 carry vm=1 ignores register
    apply(1, 1, VLEN, '1, 1, 5'd9, '0, '1, "R3 carry vm");
    // R4 / R1 direct bits
    apply(0, 0, VLEN, pat, 0, 5'd0, '0, '0, "R4 pred vm0 R1");
    apply(1, 0, VLEN, pat, 0, 5'd0, '0, '0, "R4 carry vm0 R1");
    apply(1, 0, 33, 64'h1, 1, 5'd31, pat, ~pat, "R1 bit0 R6");
    apply(0, 0, 33, 64'h1_0000_0000, 0, 5'd0, '0, '0, "R1 bit32");
    // count limits
    apply(0, 1, 1, '0, 1, 5'd1, '0, '1, "R6 cnt=1 R5");
    apply(0, 1, 0, '1, 1, 5'd2, '0, '1, "R7 cnt=0");
    apply(0, 1, VLEN + 1, '1, 1, 5'd2, '0, '1, "R7 cnt=VLEN+1");
    apply(1, 0, (1 << CNT_W) - 1, '1, 1, 5'd2, '0, '1, "R7 cnt=max");
    apply(0, 0, 5, pat, 0, 5'd4, '1, '0, "R8 idle");
    // random mix
    for (int k = 0; k < 300; k++) begin
      apply($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, VLEN + 2),
            {$urandom, $urandom}, $urandom_range(0, 1), IDX_W'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, "R4 random R5");
    end
    apply(0, 0, 1, '0, 0, 5'd0, '0, '0, "R8 drain");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 queue drained", VLEN'(exp_q.size()), '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule